// File: doc/BRIEF.md
# 1-Wire Time-Base Tick Divider

This block turns a fast system clock into the slow time-base tick that paces a 1-Wire bus master, normally 1 MHz. Software writes one 8-bit configuration byte that holds an enable bit, a shift amount and an odd prescale selector. The divide ratio is the odd prescale times two raised to the shift amount. Software picks a byte whose ratio matches its system clock. For example, 0x85 gives 6 for a 6 MHz clock, 0x95 gives 96 for 96 MHz, and 0x9C gives 128 for 128 MHz.

The block has no data stream, so there is no valid/ready handshake. The write strobe, the configuration byte and both outputs are plain control and status pins. A write is accepted in the cycle its strobe is high and cannot be held off. Every write restarts the counting from zero, so the tick phase is known relative to the write. The tick output is high for one system clock cycle per period. The enable flag shows whether ticks are being produced.

Top module: `owire_tick_div`

## Requirements
- R1: After reset the stored byte is 0x00, `tick` is 0 and `tick_en` is 0.
- R2: Bit 7 of the stored byte is the enable. `tick_en` equals that bit. While it is 0, `tick` stays 0.
- R3: Bits 1:0 select the odd prescale. Codes 0, 1, 2 and 3 give 1, 3, 5 and 7.
- R4: Bits 4:2 hold a shift n from 0 to 7, which multiplies the ratio by 2^n. For example, 0x84 gives 2, 0x8C gives 8 and 0x9C gives 128.
- R5: The period of `tick` is exactly prescale × 2^n system cycles. For example, 0x85 gives 6, 0x89 gives 12 and 0x95 gives 96.
- R6: Bits 6:5 have no effect on the tick pattern.
- R7: A write (`cfg_we` high at a rising edge) clears both counter stages. `tick` is 0 in the cycle after the write edge. The first tick follows exactly one full period after the write edge, even when the write arrives mid-period.
- R8: With ratio 1 (byte 0x80), `tick` is high in every cycle from the first cycle after the write onward.
- R9: For ratios above 1, each tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: [7] enable, [6:5] unused, [4:2] shift, [1:0] prescale code |
| tick | output | 1 | One-cycle time-base pulse |
| tick_en | output | 1 | High while the stored enable bit is set |

## Verification
A prescale counter that ends at the wrong count, or a binary stage that compares against the wrong mask, changes the spacing of `tick`. That error shows within one expected period of the write. A counter that is not cleared on a write shifts the phase of the first tick, so the first edge after the write is already wrong. The bench therefore checks every cycle from the write edge through three full periods, for all 32 prescale and shift pairs. It also runs random bytes, disabled bytes, and writes issued mid-period.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int CFG_W     = 8;
  localparam int EN_BIT    = 7;
  localparam int SHIFT_LO  = 2;
  localparam int SHIFT_W   = 3;
  localparam int PSEL_W    = 2;
  localparam int PRE_CW    = PSEL_W + 1;
  localparam int POW_CW    = (1 << SHIFT_W) - 1;

  typedef struct packed {
    logic               en;
    logic [SHIFT_W-1:0] shift;
    logic [PSEL_W-1:0]  psel;
  } owt_cfg_t;

  function automatic owt_cfg_t owt_decode(input logic [CFG_W-1:0] b);
    owt_cfg_t c;
    c.en    = b[EN_BIT];
    c.shift = b[SHIFT_LO +: SHIFT_W];
    c.psel  = b[PSEL_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/owt_prescale.sv
module owt_prescale
  import owt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [PSEL_W-1:0] psel,
  output logic              step
);
  logic [PRE_CW-1:0] cnt;
  logic [PRE_CW-1:0] last;

  // odd prescale 2*code+1 ends at count 2*code
  assign last = {psel, 1'b0};
  assign step = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || !en) cnt <= '0;
    else if (step)       cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R3
  pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= last));
endmodule

// File: rtl/owt_pow2.sv
module owt_pow2
  import owt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic               step,
  input  logic [SHIFT_W-1:0] shift,
  output logic               done
);
  logic [POW_CW-1:0] cnt;
  logic [POW_CW-1:0] last;

  // terminal count is 2^shift - 1: ones in the low shift bits
  for (genvar i = 0; i < POW_CW; i++) begin : g_mask
    assign last[i] = (SHIFT_W'(i) < shift);
  end

  assign done = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || !en) cnt <= '0;
    else if (done)       cnt <= '0;
    else if (step)       cnt <= cnt + 1'b1;
  end

  // R4
  pow_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((cnt & ~last) == '0));
endmodule

// File: rtl/owire_tick_div.sv
module owire_tick_div
  import owt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             tick,
  output logic             tick_en
);
  logic [CFG_W-1:0] cfg_q;
  owt_cfg_t         cfg;
  logic             pre_step;
  logic             period_end;
  logic             ratio_one;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign cfg      = owt_decode(cfg_q);
  assign tick_en  = cfg.en;
  assign ratio_one = (cfg.psel == '0) && (cfg.shift == '0);

  owt_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .en    (cfg.en),
    .psel  (cfg.psel),
    .step  (pre_step)
  );

  owt_pow2 u_pow (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .en    (cfg.en),
    .step  (pre_step),
    .shift (cfg.shift),
    .done  (period_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      tick <= 1'b0;
    else if (cfg_we) tick <= 1'b0;
    else             tick <= period_end;
  end

  // R2
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> tick_en);
  // R7
  quiet_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !tick);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ratio_one && !cfg_we) |=> !tick);
  // R8
  ratio_one_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio_one && !cfg_we) |=> tick);
endmodule

// File: tb/owire_tick_div_bench.sv
module owire_tick_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       tick;
  logic       tick_en;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  owire_tick_div u_owire_tick_div (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick(tick), .tick_en(tick_en)
  );

  function automatic int exp_ratio(input logic [7:0] b);
    return (2 * int'(b[1:0]) + 1) << b[4:2];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a write; returns at the negedge just after the write edge
  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // watch `periods` periods after a write; first mismatch reported
  task automatic run_pattern(input logic [7:0] b, input int periods, input string req);
    int r = exp_ratio(b);
    int err_c = -1;
    int act = 0;
    int ex = 0;
    wr(b);
    check(tick_en == b[7], "R2 tick_en", tick_en, b[7]);
    for (int c = 0; c <= periods * r; c++) begin
      int e = (b[7] && c > 0 && (c % r) == 0) ? 1 : 0;
      if (err_c < 0 && int'(tick) != e) begin
        err_c = c; act = tick; ex = e;
      end
      if (c < periods * r) @(negedge clk);
    end
    check(err_c < 0, req, act, ex);
    if (err_c >= 0) $display("  cfg=%02h cycle=%0d", b, err_c);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A1B));
    repeat (3) @(negedge clk);
    // R1
    check(tick == 1'b0, "R1 tick", tick, 0);
    check(tick_en == 1'b0, "R1 tick_en", tick_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R1 tick after release", tick, 0);

    // R8 ratio 1
    run_pattern(8'h80, 20, "R8 every cycle");
    // R5 named examples, R4 shift examples
    run_pattern(8'h85, 3, "R5 0x85 ratio 6");
    run_pattern(8'h89, 3, "R5 0x89 ratio 12");
    run_pattern(8'h95, 3, "R5 0x95 ratio 96");
    run_pattern(8'h9C, 2, "R4 0x9C ratio 128");
    // R2 disabled: no ticks
    run_pattern(8'h15, 4, "R2 disabled silent");
    // R6 bits 6:5 ignored
    run_pattern(8'hE5, 3, "R6 bits6:5 set");
    run_pattern(8'hA9, 3, "R6 bit5 set");

    // R3/R4/R5/R9 exhaustive: all prescale and shift pairs
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 4; p++)
        run_pattern(8'h80 | 8'(s << 2) | 8'(p), 3, "R3 R4 R9 period sweep");

    // R7 mid-period rewrite restarts counting
    wr(8'h9C);
    repeat (50) @(negedge clk);
    run_pattern(8'h88, 3, "R7 restart mid-period");
    wr(8'h8F);
    repeat (13) @(negedge clk);
    run_pattern(8'h8F, 2, "R7 same value rewrite");

    // random bytes
    for (int k = 0; k < 40; k++) begin
      logic [7:0] b = 8'($urandom);
      if (k % 5 == 0) b[7] = 1'b0; else b[7] = 1'b1;
      run_pattern(b, 2, "R5 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule